// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block is the host-facing status and interrupt register of a two-channel descriptor DMA engine. The transmit and receive sequencers pulse event inputs. Each pulse latches a sticky bit, and the bit stays set until the host clears it by writing a one to its position. A companion enable register masks each event source. The block forms two summary bits from the enabled sources. The normal summary covers completion and transmit-buffer-unavailable events. The abnormal summary covers stopped-process and receive-buffer-unavailable events. One interrupt line is raised when a summary is set and that summary is itself enabled.

The status word also reports the live three-bit state codes of the transmit and receive sequencers. These fields are read-only and never raise an interrupt. Reads are combinational on the register address. Writes take effect at the next rising clock edge.

Top module: `dma_irq_status`

## Requirements
- R1: After reset all event bits and the whole enable register are zero and `irq_o` is low. A status read then shows only the state codes.
- R2: Each event input sets its sticky status bit at the next clock edge. The mapping is `ev_set_i[0]`→bit 0 (tx done), [1]→bit 1 (tx stopped), [2]→bit 2 (tx buffer unavailable), [3]→bit 6 (rx done), [4]→bit 7 (rx buffer unavailable) and [5]→bit 8 (rx stopped). A set bit stays set with no further pulse.
- R3: A write to the status address with a one at an event bit position clears that bit. A zero at that position leaves the bit unchanged.
- R4: When an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 16 is the OR of event bits 0, 2 and 6, each gated by the enable bit at the same position in the enable register.
- R6: Status bit 15 is the OR of event bits 1, 7 and 8, each gated by the enable bit at the same position in the enable register.
- R7: `irq_o` = (bit 16 AND enable bit 16) OR (bit 15 AND enable bit 15).
- R8: Status bits 22:20 show `tx_state_i` and bits 19:17 show `rx_state_i`, both combinationally. These fields have no effect on the summaries or on `irq_o`.
- R9: Writes to the status address leave the reserved, state and summary positions unaffected. The enable register stores only bits 0, 1, 2, 6, 7, 8, 15 and 16, and all its other bits read zero.
- R10: A read from any address other than the status (0x14) or enable (0x1C) offset returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte address for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| ev_set_i | input | 6 | Event pulses from the sequencers |
| tx_state_i | input | 3 | Live transmit sequencer state code |
| rx_state_i | input | 3 | Live receive sequencer state code |
| irq_o | output | 1 | Interrupt request |

## Verification
Event pulses and register writes are due one edge later. The bench drives them in the low clock phase and applies its model update at the same rising edge. It compares the status word, the enable word and `irq_o` in the next low phase. The state fields and the read mux are combinational, so the bench changes the state codes or the address and compares a short delay later, with no edge in between. The set-versus-clear race and writes to the unimplemented bit positions are also checked one edge later.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_EV  = 6;
  localparam int ST_W    = 3;
  localparam int NIS_BIT = 16;
  localparam int AIS_BIT = 15;
  localparam int TXS_LSB = 20;
  localparam int RXS_LSB = 17;

  // event index -> bit position in status/enable words
  function automatic int ev_pos(input int idx);
    case (idx)
      0: ev_pos = 0;
      1: ev_pos = 1;
      2: ev_pos = 2;
      3: ev_pos = 6;
      4: ev_pos = 7;
      default: ev_pos = 8;
    endcase
  endfunction

  localparam logic [NUM_EV-1:0] NORM_MASK = 6'b001101;
  localparam logic [NUM_EV-1:0] ABN_MASK  = 6'b110010;
endpackage

// File: rtl/dma_irq_sticky.sv
module dma_irq_sticky
  import dma_irq_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set dominates clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic [NUM_EV-1:0] ev_q_i,
  input  logic [NUM_EV-1:0] ena_ev_i,
  input  logic              ena_nis_i,
  input  logic              ena_ais_i,
  output logic              nis_o,
  output logic              ais_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] live;

  always_comb begin
    live  = ev_q_i & ena_ev_i;
    nis_o = |(live & NORM_MASK);
    ais_o = |(live & ABN_MASK);
    irq_o = (nis_o & ena_nis_i) | (ais_o & ena_ais_i);
  end
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_EV-1:0] ev_q_i,
  input  logic              nis_i,
  input  logic              ais_i,
  input  logic [ST_W-1:0]   tx_state_i,
  input  logic [ST_W-1:0]   rx_state_i,
  output logic [NUM_EV-1:0] ev_clr_o,
  output logic [NUM_EV-1:0] ena_ev_o,
  output logic              ena_nis_o,
  output logic              ena_ais_o
);
  logic sel_stat, sel_ena;
  logic [REG_W-1:0] stat_word, ena_word;

  assign sel_stat = (addr_i == STAT_OFS);
  assign sel_ena  = (addr_i == ENA_OFS);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    localparam int P = ev_pos(i);
    assign ev_clr_o[i] = wr_i & sel_stat & wdata_i[P];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              ena_ev_o[i] <= 1'b0;
      else if (wr_i && sel_ena) ena_ev_o[i] <= wdata_i[P];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_nis_o <= 1'b0;
      ena_ais_o <= 1'b0;
    end else if (wr_i && sel_ena) begin
      ena_nis_o <= wdata_i[NIS_BIT];
      ena_ais_o <= wdata_i[AIS_BIT];
    end
  end

  always_comb begin
    stat_word = '0;
    ena_word  = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      stat_word[ev_pos(i)] = ev_q_i[i];
      ena_word[ev_pos(i)]  = ena_ev_o[i];
    end
    stat_word[NIS_BIT] = nis_i;
    stat_word[AIS_BIT] = ais_i;
    stat_word[TXS_LSB +: ST_W] = tx_state_i;
    stat_word[RXS_LSB +: ST_W] = rx_state_i;
    ena_word[NIS_BIT] = ena_nis_o;
    ena_word[AIS_BIT] = ena_ais_o;
    if (sel_stat)     rdata_o = stat_word;
    else if (sel_ena) rdata_o = ena_word;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_EV-1:0] ev_set_i,
  input  logic [ST_W-1:0]   tx_state_i,
  input  logic [ST_W-1:0]   rx_state_i,
  output logic              irq_o
);
  logic [NUM_EV-1:0] ev_q, ev_clr, ena_ev;
  logic ena_nis, ena_ais, nis, ais;

  dma_irq_sticky #(.N(NUM_EV)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_set_i),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  dma_irq_summary u_sum (
    .ev_q_i   (ev_q),
    .ena_ev_i (ena_ev),
    .ena_nis_i(ena_nis),
    .ena_ais_i(ena_ais),
    .nis_o    (nis),
    .ais_o    (ais),
    .irq_o    (irq_o)
  );

  dma_irq_regif #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .ENA_OFS(ENA_OFS)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ev_q_i    (ev_q),
    .nis_i     (nis),
    .ais_i     (ais),
    .tx_state_i(tx_state_i),
    .rx_state_i(rx_state_i),
    .ev_clr_o  (ev_clr),
    .ena_ev_o  (ena_ev),
    .ena_nis_o (ena_nis),
    .ena_ais_o (ena_ais)
  );
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
  import dma_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_EV-1:0] ev_set_i,
  input logic [NUM_EV-1:0] ev_clr,
  input logic [NUM_EV-1:0] ev_q,
  input logic [NUM_EV-1:0] ena_ev,
  input logic              ena_nis,
  input logic              ena_ais,
  input logic              irq_o
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_set_i != '0) |=> ((ev_q & $past(ev_set_i)) == $past(ev_set_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_q & ~ev_clr) != '0) |=> ((ev_q & $past(ev_q & ~ev_clr)) == $past(ev_q & ~ev_clr)));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_set_i & ev_clr) != '0) |=> ((ev_q & $past(ev_set_i & ev_clr)) == $past(ev_set_i & ev_clr)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_clr & ~ev_set_i) != '0) |=> ((ev_q & $past(ev_clr & ~ev_set_i)) == '0));

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_nis && !ena_ais) |-> !irq_o);

  p_irq_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ev_q & ena_ev) != '0));
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ev_set_i(ev_set_i),
  .ev_clr  (ev_clr),
  .ev_q    (ev_q),
  .ena_ev  (ena_ev),
  .ena_nis (ena_nis),
  .ena_ais (ena_ais),
  .irq_o   (irq_o)
);

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_ENA  = 8'h1C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0] ev = '0;
  logic [2:0] txs = '0, rxs = '0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  logic [5:0] m_ev = '0, m_ena = '0;
  logic m_en_n = 1'b0, m_en_a = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_set_i(ev),
    .tx_state_i(txs), .rx_state_i(rxs), .irq_o(irq)
  );

  function automatic int bpos(int i);
    int t[6] = '{0, 1, 2, 6, 7, 8};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    logic [5:0] l = m_ev & m_ena;
    for (int i = 0; i < 6; i++) s[bpos(i)] = m_ev[i];
    s[16] = l[0] | l[2] | l[3];
    s[15] = l[1] | l[4] | l[5];
    s[22:20] = txs;
    s[19:17] = rxs;
    return s;
  endfunction

  function automatic logic [31:0] exp_ena();
    logic [31:0] s = '0;
    for (int i = 0; i < 6; i++) s[bpos(i)] = m_ena[i];
    s[16] = m_en_n;
    s[15] = m_en_a;
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_stat();
    return (s[16] & m_en_n) | (s[15] & m_en_a);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic check_all(string tag);
    read_chk({tag, " status"}, A_STAT, exp_stat());
    read_chk({tag, " enable"}, A_ENA, exp_ena());
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  // one clock: inputs applied in low phase, model updated at edge
  task automatic cycle(logic [5:0] e, logic w, logic [7:0] a, logic [31:0] d);
    ev = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    if (w && a == A_STAT)
      for (int i = 0; i < 6; i++) if (d[bpos(i)]) m_ev[i] = 1'b0;
    if (w && a == A_ENA) begin
      for (int i = 0; i < 6; i++) m_ena[i] = d[bpos(i)];
      m_en_n = d[16];
      m_en_a = d[15];
    end
    m_ev = m_ev | e;
    @(negedge clk);
    ev = '0; wr = 1'b0; wdata = '0;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    txs = 3'd5; rxs = 3'd3;
    repeat (3) @(negedge clk);
    #1;
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R2: each event individually, sticky
    for (int i = 0; i < 6; i++) begin
      cycle(6'd1 << i, 1'b0, A_STAT, '0);
      check_all("R2 set");
    end
    cycle('0, 1'b0, A_STAT, '0);
    check_all("R2 held");

    // R3: write-one-to-clear subset, zeros untouched
    cycle('0, 1'b1, A_STAT, 32'h0000_0041);
    check_all("R3 w1c");
    // R9: write to reserved/state/summary positions
    cycle('0, 1'b1, A_STAT, 32'hFFFF_FE38);
    check_all("R9 status ro");
    cycle('0, 1'b1, A_ENA, 32'hFFFF_FFFF);
    check_all("R9 enable all ones");
    read_chk("R9 enable stored bits", A_ENA, 32'h0001_81C7);

    // R5/R6/R7 masked summaries
    cycle('0, 1'b1, A_ENA, 32'h0001_0005);
    check_all("R5 normal enabled");
    cycle('0, 1'b1, A_ENA, 32'h0000_8186);
    check_all("R6 abnormal enabled");
    cycle('0, 1'b1, A_ENA, 32'h0000_01C7);
    check_all("R7 summary enables off");
    chk("R7 irq off", {31'd0, irq}, 32'd0);

    // R4: set and clear same bit
    cycle(6'b000001, 1'b1, A_STAT, 32'h0000_01C7);
    check_all("R4 set wins");
    read_chk("R4 bit0 set", A_STAT, exp_stat());

    // R8: state fields live, no irq effect
    cycle('0, 1'b1, A_STAT, 32'h0000_01C7);
    cycle('0, 1'b1, A_ENA, 32'h0001_81C7);
    for (int k = 0; k < 8; k++) begin
      txs = 3'(k); rxs = 3'(7 - k);
      #1;
      check_all("R8 state live");
    end

    // R10: other addresses
    cycle(6'b111111, 1'b0, A_STAT, '0);
    cycle('0, 1'b1, 8'h18, 32'hFFFF_FFFF);
    check_all("R10 stray write");
    read_chk("R10 stray read", 8'h00, 32'h0);
    read_chk("R10 stray read", 8'h15, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e = 6'($urandom) & 6'($urandom);
      logic w = ($urandom % 3) != 0;
      logic [31:0] d = $urandom;
      logic [7:0] a;
      case ($urandom % 4)
        0, 1: a = A_STAT;
        2: a = A_ENA;
        default: a = 8'($urandom);
      endcase
      txs = 3'($urandom); rxs = 3'($urandom);
      cycle(e, w, a, d);
      check_all("R5 R6 R7 random");
      begin
        logic [7:0] ra = 8'($urandom);
        if (ra != A_STAT && ra != A_ENA) read_chk("R10 random read", ra, 32'h0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule